// File: doc/BRIEF.md
# MDIO Management Access Controller

This block is the master side of a two-wire management interface used to read and write registers inside Ethernet PHYs. Software owns two 32-bit registers: a control register that turns the serial clock on and picks its divider, and an access register that holds the command. Writing the access register with its start flag set launches one transaction: the block sends a 32-bit preamble, the start and opcode bits, the PHY and register addresses, the turnaround and 16 data bits, all most significant bit first. The start flag stays set until the transaction ends and then clears itself. Software polls the flag before and after each access.

For a read, the block releases the data line at the turnaround. It records whether the PHY pulled the second turnaround bit low, and it shifts the 16 returned bits into the data field of the access register. The returned data is only valid when the acknowledge flag is set.

The register port is a plain write strobe with a select line. Both registers are always visible on their read buses, so there is no read handshake and no back-pressure. The serial pins are a push-pull output, an output enable and the returned line value.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset the control readback is 0x8000_0000 (idle flag at bit 31 set, enable at bit 30 clear, divider zero), the access readback is zero, and `mdc` and `mdio_oe` are low.
- R2: With enable set, `mdc` has a period of 2×(divider+1) system clocks, where the divider is control bits DIV_W-1:0. With enable clear, `mdc` holds its level.
- R3: A write transaction (access bit 30 = 1) sends, MSB first: 32 ones, 01, opcode 01, PHY address (access bits 20:16), register address (bits 25:21), turnaround 10, then data bits 15:0.
- R4: A read transaction (bit 30 = 0) sends opcode 10 and releases `mdio_oe` from the first turnaround bit to the end of the frame.
- R5: `mdio_o` changes only on an edge where `mdc` falls. The returned line is sampled on the edge where `mdc` rises.
- R6: A write to the access register with bit 31 set, made while bit 31 is clear, sets bit 31. The bit stays set for the whole transaction and clears itself afterwards. Control bit 31 reads 0 while a command is pending or running, and `mdio_oe` is only high while access bit 31 is set.
- R7: After a read, access bit 29 is 1 exactly when the PHY drove the second turnaround bit low, and bits 15:0 hold the 16 bits the PHY returned.
- R8: A read from an address where no PHY answers leaves access bit 29 at 0.
- R9: A write to the access register while bit 31 is set has no effect on the command fields or on the transaction in flight.
- R10: While enable is clear, a pending command does not start: bit 31 stays set and nothing is driven until enable is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control, 1 selects access register |
| reg_wdata | input | 32 | Register write data |
| ctrl_rdata | output | 32 | Control readback: idle(31), enable(30), divider |
| access_rdata | output | 32 | Access readback: start(31), write(30), ack(29), reg(25:21), phy(20:16), data(15:0) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Serial data output enable |
| mdio_i | input | 1 | Serial data line value |

## Verification
A register write takes effect at the next clock edge, so the start flag and the cleared idle flag are checked at the falling system edge one cycle after the strobe. The frame starts at the first falling `mdc` edge after the flag is set and takes 64 `mdc` periods. The start flag clears one system clock after the rising `mdc` edge that samples the last data bit. A PHY model in the bench decodes the line at every rising `mdc` edge, using the line value settled half a system cycle earlier, and returns read data after each falling edge. The scoreboard compares each transaction in the cycle where the start flag is first seen low, when the PHY capture and the latched read data are both final. Divider periods are measured between consecutive rising `mdc` edges in system-clock cycles.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_LEN   = 32;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  localparam int FRAME_LEN = PRE_LEN + 4 + 2 * ADDR_W + 2 + DATA_W;
  localparam int TA1_POS   = PRE_LEN + 4 + 2 * ADDR_W;
  localparam int DATA_POS  = TA1_POS + 2;

  localparam int GO_BIT  = 31;
  localparam int WR_BIT  = 30;
  localparam int ACK_BIT = 29;
  localparam int RG_LSB  = 21;
  localparam int PHY_LSB = 16;

  localparam int IDLE_BIT = 31;
  localparam int EN_BIT   = 30;

  typedef enum logic {ENG_IDLE, ENG_SHIFT} eng_state_e;

  function automatic logic [FRAME_LEN-1:0] build_frame(
    input logic              wr,
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] rg,
    input logic [DATA_W-1:0] d
  );
    logic [1:0] op;
    logic [1:0] ta;
    logic [DATA_W-1:0] pay;
    op  = wr ? 2'b01 : 2'b10;
    ta  = wr ? 2'b10 : 2'b11;
    pay = wr ? d : {DATA_W{1'b1}};
    return {{PRE_LEN{1'b1}}, 2'b01, op, phy, rg, ta, pay};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             tick;

  // a tick marks the system edge on which mdc toggles
  assign tick = en && (cnt_q >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (en) begin
      if (tick) begin
        cnt_q <= '0;
        mdc_q <= ~mdc_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign mdc       = mdc_q;
  assign rise_tick = tick && !mdc_q;
  assign fall_tick = tick && mdc_q;
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr,
  input  logic [ADDR_W-1:0] phy,
  input  logic [ADDR_W-1:0] rg,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic              mdo,
  output logic              mdo_oe
);
  localparam int IDX_W = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] TA1_IDX  = IDX_W'(TA1_POS);
  localparam logic [IDX_W-1:0] TA2_IDX  = IDX_W'(TA1_POS + 1);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(DATA_POS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  eng_state_e           state_q;
  logic [FRAME_LEN-1:0] tx_sr;
  logic [IDX_W-1:0]     idx_q;
  logic [IDX_W-1:0]     idx_nx;
  logic                 rd_q;
  logic                 oe_q;
  logic                 ack_q;
  logic                 done_q;
  logic [DATA_W-1:0]    rx_sr;

  assign idx_nx = idx_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      tx_sr   <= '0;
      idx_q   <= '0;
      rd_q    <= 1'b0;
      oe_q    <= 1'b0;
      ack_q   <= 1'b0;
      done_q  <= 1'b0;
      rx_sr   <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ENG_IDLE: begin
          if (start && fall_tick) begin
            tx_sr   <= build_frame(wr, phy, rg, wdata);
            idx_q   <= '0;
            rd_q    <= !wr;
            oe_q    <= 1'b1;
            ack_q   <= 1'b0;
            state_q <= ENG_SHIFT;
          end
        end
        ENG_SHIFT: begin
          if (rise_tick) begin
            if (rd_q && idx_q == TA2_IDX) ack_q <= !mdio_i;
            if (rd_q && idx_q >= DATA_IDX) rx_sr <= {rx_sr[DATA_W-2:0], mdio_i};
            if (idx_q == LAST_IDX) begin
              state_q <= ENG_IDLE;
              done_q  <= 1'b1;
              oe_q    <= 1'b0;
            end
          end else if (fall_tick) begin
            idx_q <= idx_nx;
            tx_sr <= {tx_sr[FRAME_LEN-2:0], 1'b0};
            oe_q  <= !(rd_q && idx_nx >= TA1_IDX);
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  assign busy   = (state_q != ENG_IDLE);
  assign done   = done_q;
  assign ack    = ack_q;
  assign rdata  = rx_sr;
  assign mdo    = tx_sr[FRAME_LEN-1];
  assign mdo_oe = oe_q;
endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] ctrl_rdata,
  output logic [31:0] access_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int PAD_W = 30 - DIV_W;

  logic              en_q;
  logic [DIV_W-1:0]  div_q;
  logic              go_q;
  logic              wr_q;
  logic              ack_q;
  logic [ADDR_W-1:0] rg_q;
  logic [ADDR_W-1:0] phy_q;
  logic [DATA_W-1:0] data_q;

  logic              rise_tick;
  logic              fall_tick;
  logic              eng_busy;
  logic              eng_done;
  logic              eng_ack;
  logic [DATA_W-1:0] eng_rdata;
  logic              eng_start;
  logic              acc_wr_ok;
  logic              unused_wbits;

  assign unused_wbits = ^reg_wdata[29:26];
  assign acc_wr_ok    = reg_wr && reg_sel && !go_q;
  assign eng_start    = go_q && !eng_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      div_q <= '0;
    end else if (reg_wr && !reg_sel) begin
      en_q  <= reg_wdata[EN_BIT];
      div_q <= reg_wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q   <= 1'b0;
      wr_q   <= 1'b0;
      ack_q  <= 1'b0;
      rg_q   <= '0;
      phy_q  <= '0;
      data_q <= '0;
    end else if (acc_wr_ok) begin
      go_q   <= reg_wdata[GO_BIT];
      wr_q   <= reg_wdata[WR_BIT];
      ack_q  <= 1'b0;
      rg_q   <= reg_wdata[RG_LSB +: ADDR_W];
      phy_q  <= reg_wdata[PHY_LSB +: ADDR_W];
      data_q <= reg_wdata[DATA_W-1:0];
    end else if (eng_done) begin
      go_q <= 1'b0;
      if (!wr_q) begin
        ack_q  <= eng_ack;
        data_q <= eng_rdata;
      end
    end
  end

  mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en_q),
    .div       (div_q),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_engine u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (eng_start),
    .wr        (wr_q),
    .phy       (phy_q),
    .rg        (rg_q),
    .wdata     (data_q),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .busy      (eng_busy),
    .done      (eng_done),
    .ack       (eng_ack),
    .rdata     (eng_rdata),
    .mdo       (mdio_o),
    .mdo_oe    (mdio_oe)
  );

  assign ctrl_rdata   = {!eng_busy && !go_q, en_q, {PAD_W{1'b0}}, div_q};
  assign access_rdata = {go_q, wr_q, ack_q, 3'b000, rg_q, phy_q, data_q};
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_wr,
  input logic        go,
  input logic [10:0] acc_ctl,
  input logic        idle,
  input logic        en,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  // R6: the line is only driven while a command is outstanding
  p_oe_needs_go_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> go);

  // R6: idle status implies the line is released
  p_idle_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !mdio_oe);

  // R9: access writes during a command leave the command fields alone
  p_busy_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && go) |=> (acc_ctl == $past(acc_ctl)));

  // R2: mdc holds its level while disabled
  p_mdc_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(mdc));

  // R5: serial output only moves with a falling mdc
  p_mdo_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> $fell(mdc));
endmodule

bind mdio_mgmt mdio_mgmt_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .acc_wr  (reg_wr && reg_sel),
  .go      (access_rdata[31]),
  .acc_ctl ({access_rdata[30], access_rdata[25:16]}),
  .idle    (ctrl_rdata[31]),
  .en      (ctrl_rdata[30]),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe)
);

// File: tb/mdio_mgmt_tb_top.sv
module mdio_mgmt_tb_top;
  localparam logic [4:0] PHY_ADDR = 5'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] ctrl_rdata;
  logic [31:0] access_rdata;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_i;
  logic        phy_oe = 1'b0;
  logic        phy_bit = 1'b1;

  assign mdio_i = mdio_oe ? mdio_o : (phy_oe ? phy_bit : 1'b1);

  always #5 clk = ~clk;

  mdio_mgmt dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_sel      (reg_sel),
    .reg_wdata    (reg_wdata),
    .ctrl_rdata   (ctrl_rdata),
    .access_rdata (access_rdata),
    .mdc          (mdc),
    .mdio_o       (mdio_o),
    .mdio_oe      (mdio_oe),
    .mdio_i       (mdio_i)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // ---------------- PHY model ----------------
  logic        line_prev = 1'b1;
  logic        oe_prev = 1'b0;
  logic        mdo_prev = 1'b0;
  logic        mdc_prev = 1'b0;
  int          r5_bad = 0;
  int          clash = 0;
  int          ta_release_bad = 0;
  int          ones = 0;
  int          pos = -1;
  int          frames = 0;
  logic [12:0] hdr;
  logic        is_rd = 1'b0;
  logic        match = 1'b0;
  logic [15:0] wd;
  logic [15:0] rd_word;
  logic [1:0]  ta;
  logic [15:0] mem [32];
  logic [4:0]  last_phy, last_reg;
  logic [1:0]  last_op, last_ta;
  logic [15:0] last_wd;

  initial for (int i = 0; i < 32; i++) mem[i] = '0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (mdio_o !== mdo_prev && !(mdc_prev == 1'b1 && mdc == 1'b0)) r5_bad++;
      if (mdio_oe && phy_oe) clash++;
    end
    line_prev = mdio_i;
    oe_prev   = mdio_oe;
    mdo_prev  = mdio_o;
    mdc_prev  = mdc;
  end

  always @(posedge mdc) begin
    if (pos < 0) begin
      if (line_prev) ones++;
      else begin
        if (ones >= 32) pos = 33;
        ones = 0;
      end
    end else begin
      if (pos <= 45) begin
        hdr = {hdr[11:0], line_prev};
        if (pos == 45) begin
          last_op  = hdr[11:10];
          last_phy = hdr[9:5];
          last_reg = hdr[4:0];
          is_rd    = (hdr[11:10] == 2'b10);
          match    = (hdr[9:5] == PHY_ADDR);
          rd_word  = mem[hdr[4:0]];
        end
      end else if (pos <= 47) begin
        if (pos == 46 && is_rd && oe_prev) ta_release_bad++;  // R4
        ta = {ta[0], line_prev};
      end else begin
        wd = {wd[14:0], line_prev};
      end
      if (pos == 63) begin
        if (!is_rd) begin
          last_ta = ta;
          last_wd = wd;
          if (match) mem[last_reg] = wd;
        end
        frames++;
        pos = -1;
        ones = 0;
      end else pos++;
    end
  end

  always @(negedge mdc) begin
    #1;
    if (pos >= 47 && pos <= 63 && is_rd && match) begin
      phy_oe  = 1'b1;
      phy_bit = (pos == 47) ? 1'b0 : rd_word[63 - pos];
    end else begin
      phy_oe = 1'b0;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] data;
    logic        ack;
  } exp_t;

  exp_t sb_q[$];
  logic prev_go = 1'b0;

  always @(negedge clk) begin
    if (rst_n && prev_go && !access_rdata[31]) begin
      if (sb_q.size() == 0) chk("R6 unexpected completion", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        if (e.wr) begin
          chk("R3 write opcode", {30'd0, last_op}, 32'h1);
          chk("R3 write phy addr", {27'd0, last_phy}, {27'd0, e.phy});
          chk("R3 write reg addr", {27'd0, last_reg}, {27'd0, e.rg});
          chk("R3 write turnaround", {30'd0, last_ta}, 32'h2);
          chk("R3 write data", {16'd0, last_wd}, {16'd0, e.data});
        end else begin
          chk("R4 read opcode", {30'd0, last_op}, 32'h2);
          chk("R4 read phy addr", {27'd0, last_phy}, {27'd0, e.phy});
          chk("R7 read ack", {31'd0, access_rdata[29]}, {31'd0, e.ack});
          if (e.ack) chk("R7 read data", {16'd0, access_rdata[15:0]}, {16'd0, e.data});
          else chk("R8 absent phy no ack", {31'd0, access_rdata[29]}, 32'd0);
        end
      end
    end
    prev_go = access_rdata[31];
  end

  // ---------------- driver ----------------
  task automatic reg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic logic [31:0] acc_word(input logic wr, input logic [4:0] phy,
                                           input logic [4:0] rg, input logic [15:0] d);
    return {1'b1, wr, 4'b0000, rg, phy, d};
  endfunction

  task automatic issue(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] d, input logic [15:0] exp_d, input logic exp_ack);
    exp_t e;
    e.wr = wr; e.phy = phy; e.rg = rg; e.data = exp_d; e.ack = exp_ack;
    sb_q.push_back(e);
    reg_write(1'b1, acc_word(wr, phy, rg, d));
  endtask

  task automatic wait_done();
    while (access_rdata[31]) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic period(output int p);
    int t0;
    @(posedge mdc); t0 = cyc;
    @(posedge mdc); p = cyc - t0;
  endtask

  initial begin
    int p;
    logic m0;
    int f0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ctrl reset", ctrl_rdata, 32'h8000_0000);
    chk("R1 access reset", access_rdata, 32'h0);
    chk("R1 mdc reset", {31'd0, mdc}, 32'd0);
    chk("R1 oe reset", {31'd0, mdio_oe}, 32'd0);

    reg_write(1'b0, 32'h4000_0000);
    period(p);
    chk("R2 period div0", p, 2);

    issue(1'b1, PHY_ADDR, 5'd5, 16'hA5C3, 16'hA5C3, 1'b0);
    chk("R6 go set", {31'd0, access_rdata[31]}, 32'd1);
    chk("R6 idle clear", {31'd0, ctrl_rdata[31]}, 32'd0);
    wait_done();
    chk("R6 idle after", {31'd0, ctrl_rdata[31]}, 32'd1);

    issue(1'b0, PHY_ADDR, 5'd5, 16'h0000, 16'hA5C3, 1'b1);
    wait_done();

    reg_write(1'b0, 32'h4000_0003);
    period(p);
    chk("R2 period div3", p, 8);

    issue(1'b1, PHY_ADDR, 5'd31, 16'h0001, 16'h0001, 1'b0);
    wait_done();
    issue(1'b0, PHY_ADDR, 5'd31, 16'hFFFF, 16'h0001, 1'b1);
    wait_done();

    issue(1'b0, 5'd7, 5'd2, 16'h0000, 16'hFFFF, 1'b0);
    wait_done();

    issue(1'b0, PHY_ADDR, 5'd5, 16'h0000, 16'hA5C3, 1'b1);
    reg_write(1'b1, acc_word(1'b1, 5'd9, 5'd2, 16'h1234));
    chk("R9 reg field kept", {27'd0, access_rdata[25:21]}, 32'd5);
    chk("R9 phy field kept", {27'd0, access_rdata[20:16]}, {27'd0, PHY_ADDR});
    chk("R9 write flag kept", {31'd0, access_rdata[30]}, 32'd0);
    wait_done();
    chk("R9 no write landed", {16'd0, mem[2]}, 32'd0);

    reg_write(1'b0, 32'h0000_0003);
    m0 = mdc;
    repeat (30) begin
      @(negedge clk);
      if (mdc !== m0) m0 = 1'bx;
    end
    chk("R2 mdc held disabled", {31'd0, m0}, {31'd0, mdc});
    f0 = frames;
    issue(1'b0, PHY_ADDR, 5'd31, 16'h0000, 16'h0001, 1'b1);
    repeat (300) @(negedge clk);
    chk("R10 go pending", {31'd0, access_rdata[31]}, 32'd1);
    chk("R10 no frame", frames, f0);
    chk("R10 line released", {31'd0, mdio_oe}, 32'd0);
    reg_write(1'b0, 32'h4000_0001);
    wait_done();

    chk("R5 edge discipline", r5_bad, 0);
    chk("R4 turnaround release", ta_release_bad, 0);
    chk("R4 no drive clash", clash, 0);
    chk("R6 scoreboard drained", sb_q.size(), 0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule